// File: doc/BRIEF.md
# Sparsified Strip Readout Serializer

The block takes one event at a time: 128 strip channels of 7-bit digitized samples, presented in parallel on a single wide input with a valid/ready handshake. At the moment it accepts the event it also samples its configuration: a threshold, a static pedestal, and three mode switches. The switches enable sparsification, neighbour keeping and dynamic pedestal removal.

Each channel is corrected by removing the static pedestal and, optionally, a baseline computed over the whole event. The corrected value is then compared with the threshold. The block emits one byte per clock. For each kept channel, in ascending channel order, it emits the channel number and then the corrected value. Every event closes with a marker byte. A new event is accepted only after the current one has been fully emitted.

Top module: `ssr_serializer`

## Requirements
- R1: After reset `in_ready` is 1 and `out_valid` is 0. An event is accepted on a rising edge where `in_valid` and `in_ready` are both 1. `in_ready` stays 0 from that edge until the cycle in which the marker byte is on the output, and it is 1 again in that cycle.
- R2: The corrected value of a channel is max(0, raw − pedestal − baseline). The baseline is floor(sum of all 128 raw values / 128) when dynamic pedestal removal is on, and 0 when it is off.
- R3: With sparsification off, all 128 channels are emitted in the order 0, 1, …, 127, whatever the threshold.
- R4: With sparsification on, a channel is a hit when its corrected value is greater than or equal to the threshold. Kept channels are emitted in strictly ascending channel order.
- R5: With the neighbour option on (and sparsification on), channels i−1 and i+1 of every hit i are also kept. There is no wraparound: channel 0 has no lower neighbour and channel 127 has no upper neighbour.
- R6: A channel that is both a hit and a neighbour, or a neighbour of two hits, is emitted exactly once.
- R7: Each kept channel produces two bytes in this order: the address byte (channel number, 0–127, bit 7 = 0), then the value byte (corrected value, bit 7 = 0). Every event ends with the byte 0xFF with `out_last` = 1, including an event with no kept channels. `out_last` is 1 on no other byte.
- R8: The first output byte of an event appears in the third cycle after the accepting edge. All bytes of the event, including the marker, follow on consecutive cycles with no gap.
- R9: Configuration inputs are sampled only on the accepting edge. Changing them while an event is being emitted has no effect on that event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Event samples are present |
| in_ready | output | 1 | Block can accept an event |
| in_samples | input | 896 | Channel i occupies bits [7i+6:7i] |
| cfg_threshold | input | 7 | Hit threshold in counts |
| cfg_pedestal | input | 6 | Static pedestal in counts |
| cfg_sparse | input | 1 | 1 = emit only kept channels, 0 = emit all channels |
| cfg_neighbour | input | 1 | 1 = also keep the neighbours of hits |
| cfg_dyn_ped | input | 1 | 1 = also remove the event-mean baseline |
| out_valid | output | 1 | A byte is present on `out_data` |
| out_data | output | 8 | Address, value or marker byte |
| out_last | output | 1 | Marks the 0xFF end-of-event byte |

## Verification
The first byte of an event is due in the third cycle after the accepting edge: one edge captures the event, one registers the corrected values and the keep mask, and one drives the first byte out. After that, one byte is due on every cycle up to and including the marker. `in_ready` is due high in the marker cycle. The bench drives inputs and samples outputs on falling edges, counting from the accepting edge. It checks the exact cycle of the first byte, that no gap occurs before the marker, and the ready level at every byte. It then compares the collected stream, byte for byte, with a stream computed arithmetically from the raw samples and the configuration.

// File: rtl/ssr_pkg.sv
package ssr_pkg;
   localparam int unsigned BYTE_W   = 8;
   localparam logic [7:0]  EOE_BYTE = 8'hFF;

   typedef enum logic [1:0] {
      ST_IDLE,
      ST_CALC,
      ST_SCAN,
      ST_DATA
   } scan_state_e;
endpackage

// File: rtl/ssr_baseline.sv
module ssr_baseline #(
   parameter int unsigned NCH     = 128,
   parameter int unsigned DW      = 7,
   parameter bit          HAS_DYN = 1'b1
) (
   input  logic [NCH*DW-1:0] samples,
   input  logic              enable,
   output logic [DW-1:0]     base
);
   localparam int unsigned AW = $clog2(NCH);
   localparam int unsigned SW = DW + AW;

   generate
      if (HAS_DYN) begin : g_mean
         logic [SW-1:0] total;
         always_comb begin
            total = '0;
            for (int i = 0; i < NCH; i++)
               total = total + SW'(samples[i*DW +: DW]);
         end
         // floor of the mean: NCH is a power of two
         assign base = enable ? DW'(total >> AW) : '0;
      end else begin : g_none
         assign base = '0;
      end
   endgenerate
endmodule

// File: rtl/ssr_keep.sv
module ssr_keep #(
   parameter int unsigned NCH = 128,
   parameter int unsigned DW  = 7,
   parameter int unsigned PW  = 6
) (
   input  logic [NCH*DW-1:0] samples,
   input  logic [DW-1:0]     base,
   input  logic [PW-1:0]     pedestal,
   input  logic [DW-1:0]     threshold,
   input  logic              sparse,
   input  logic              neighbour,
   output logic [NCH*DW-1:0] corr,
   output logic [NCH-1:0]    keep
);
   logic [DW:0]    offset;
   logic [NCH-1:0] hit;
   logic [NCH-1:0] adj;

   assign offset = (DW+1)'(pedestal) + (DW+1)'(base);

   for (genvar g = 0; g < NCH; g++) begin : g_ch
      logic [DW:0] raw_w;
      assign raw_w = {1'b0, samples[g*DW +: DW]};
      assign corr[g*DW +: DW] = (raw_w > offset) ? DW'(raw_w - offset) : '0;
      assign hit[g] = (corr[g*DW +: DW] >= threshold);
   end

   // shifts fill with zero, so the array edges never wrap
   assign adj  = neighbour ? ((hit << 1) | (hit >> 1)) : '0;
   assign keep = sparse ? (hit | adj) : '1;
endmodule

// File: rtl/ssr_scan.sv
module ssr_scan
   import ssr_pkg::*;
#(
   parameter int unsigned NCH = 128,
   parameter int unsigned DW  = 7
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              accept,
   input  logic [NCH*DW-1:0] corr,
   input  logic [NCH-1:0]    keep,
   output logic              busy,
   output logic              out_valid,
   output logic [7:0]        out_data,
   output logic              out_last
);
   localparam int unsigned AW = $clog2(NCH);

   scan_state_e       state;
   logic [NCH-1:0]    mask;
   logic [NCH*DW-1:0] vals;
   logic [AW-1:0]     cur;
   logic [AW-1:0]     low_idx;

   always_comb begin
      low_idx = '0;
      for (int i = NCH - 1; i >= 0; i--)
         if (mask[i]) low_idx = AW'(i);
   end

   assign busy = (state != ST_IDLE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state     <= ST_IDLE;
         mask      <= '0;
         vals      <= '0;
         cur       <= '0;
         out_valid <= 1'b0;
         out_last  <= 1'b0;
         out_data  <= '0;
      end else begin
         out_valid <= 1'b0;
         out_last  <= 1'b0;
         case (state)
            ST_IDLE: if (accept) state <= ST_CALC;
            ST_CALC: begin
               vals  <= corr;
               mask  <= keep;
               state <= ST_SCAN;
            end
            ST_SCAN: begin
               out_valid <= 1'b1;
               if (|mask) begin
                  out_data <= {{(BYTE_W-AW){1'b0}}, low_idx};
                  cur      <= low_idx;
                  state    <= ST_DATA;
               end else begin
                  out_data <= EOE_BYTE;
                  out_last <= 1'b1;
                  state    <= ST_IDLE;
               end
            end
            ST_DATA: begin
               out_valid <= 1'b1;
               out_data  <= {{(BYTE_W-DW){1'b0}}, vals[cur*DW +: DW]};
               mask[cur] <= 1'b0;
               state     <= ST_SCAN;
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   p_once_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_DATA) |=> ($countones(mask) == $countones($past(mask)) - 1));
   p_ascend_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_SCAN && $past(state) == ST_DATA && |mask) |-> (low_idx > $past(cur)));
   p_marker_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && out_last) |-> (out_data == EOE_BYTE));
   p_range_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_last) |-> !out_data[7]);
   p_nogap_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_last) |=> out_valid);
endmodule

// File: rtl/ssr_serializer.sv
module ssr_serializer #(
   parameter int unsigned NCH     = 128,
   parameter int unsigned DW      = 7,
   parameter int unsigned PW      = 6,
   parameter bit          HAS_DYN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   output logic              in_ready,
   input  logic [NCH*DW-1:0] in_samples,
   input  logic [DW-1:0]     cfg_threshold,
   input  logic [PW-1:0]     cfg_pedestal,
   input  logic              cfg_sparse,
   input  logic              cfg_neighbour,
   input  logic              cfg_dyn_ped,
   output logic              out_valid,
   output logic [7:0]        out_data,
   output logic              out_last
);
   localparam int unsigned AW = $clog2(NCH);

   generate
      if ((NCH & (NCH - 1)) != 0 || NCH < 4) begin : g_bad_nch
         $error("NCH must be a power of two of at least 4");
      end
      if (AW > 7 || DW > 7) begin : g_bad_width
         $error("address and value must fit below the marker byte");
      end
      if (PW > DW) begin : g_bad_ped
         $error("pedestal width must not exceed sample width");
      end
   endgenerate

   logic              accept;
   logic              busy;
   logic [NCH*DW-1:0] samples_q;
   logic [DW-1:0]     thr_q;
   logic [PW-1:0]     ped_q;
   logic              sparse_q, nbr_q, dyn_q;
   logic [DW-1:0]     base;
   logic [NCH*DW-1:0] corr;
   logic [NCH-1:0]    keep;

   assign in_ready = !busy;
   assign accept   = in_valid && in_ready;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         samples_q <= '0;
         thr_q     <= '0;
         ped_q     <= '0;
         sparse_q  <= 1'b0;
         nbr_q     <= 1'b0;
         dyn_q     <= 1'b0;
      end else if (accept) begin
         samples_q <= in_samples;
         thr_q     <= cfg_threshold;
         ped_q     <= cfg_pedestal;
         sparse_q  <= cfg_sparse;
         nbr_q     <= cfg_neighbour;
         dyn_q     <= cfg_dyn_ped;
      end
   end

   ssr_baseline #(.NCH(NCH), .DW(DW), .HAS_DYN(HAS_DYN)) u_base (
      .samples (samples_q),
      .enable  (dyn_q),
      .base    (base)
   );

   ssr_keep #(.NCH(NCH), .DW(DW), .PW(PW)) u_keep (
      .samples   (samples_q),
      .base      (base),
      .pedestal  (ped_q),
      .threshold (thr_q),
      .sparse    (sparse_q),
      .neighbour (nbr_q),
      .corr      (corr),
      .keep      (keep)
   );

   ssr_scan #(.NCH(NCH), .DW(DW)) u_scan (
      .clk       (clk),
      .rst_n     (rst_n),
      .accept    (accept),
      .corr      (corr),
      .keep      (keep),
      .busy      (busy),
      .out_valid (out_valid),
      .out_data  (out_data),
      .out_last  (out_last)
   );

   p_busy_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_last) |-> !in_ready);
   p_accept_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_ready) |=> !in_ready);
endmodule

// File: tb/sim_ssr_serializer.sv
module sim_ssr_serializer;
   localparam int NCH = 128;
   localparam int DW  = 7;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              in_valid = 1'b0;
   logic              in_ready;
   logic [NCH*DW-1:0] in_samples = '0;
   logic [6:0]        cfg_threshold = '0;
   logic [5:0]        cfg_pedestal = '0;
   logic              cfg_sparse = 1'b0, cfg_neighbour = 1'b0, cfg_dyn_ped = 1'b0;
   logic              out_valid;
   logic [7:0]        out_data;
   logic              out_last;

   always #10 clk = ~clk;

   ssr_serializer u0 (.*);

   int checks = 0;
   int failures = 0;
   int raw [NCH];
   int exp_b [300];
   int exp_n;
   int got_b [300];
   int got_n;

   task automatic chk(input bit ok, input string req, input string what, input int act, input int expv);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, expv);
      end
   endtask

   function automatic void build_expect(input int thr, input int ped, input bit sp, input bit nb, input bit dy);
      int  sum, base;
      int  corr [NCH];
      bit  hit [NCH];
      bit  kp;
      sum = 0;
      for (int i = 0; i < NCH; i++) sum += raw[i];
      base = dy ? sum / NCH : 0;
      for (int i = 0; i < NCH; i++) begin
         corr[i] = raw[i] - ped - base;
         if (corr[i] < 0) corr[i] = 0;
         hit[i] = (corr[i] >= thr);
      end
      exp_n = 0;
      for (int i = 0; i < NCH; i++) begin
         kp = !sp || hit[i] || (nb && i > 0 && hit[i-1]) || (nb && i < NCH - 1 && hit[i+1]);
         if (kp) begin
            exp_b[exp_n] = i; exp_b[exp_n+1] = corr[i]; exp_n += 2;
         end
      end
      exp_b[exp_n] = 255; exp_n++;
   endfunction

   task automatic run_event(input int thr, input int ped, input bit sp, input bit nb, input bit dy,
                            input bit perturb, input string req);
      int  lat;
      bit  gap, rdy_bad, bad;
      int  first_bad;
      @(negedge clk);
      chk(in_ready === 1'b1, "R1", "ready before event", int'(in_ready), 1);
      for (int i = 0; i < NCH; i++) in_samples[i*DW +: DW] = 7'(raw[i]);
      cfg_threshold = 7'(thr); cfg_pedestal = 6'(ped);
      cfg_sparse = sp; cfg_neighbour = nb; cfg_dyn_ped = dy;
      in_valid = 1'b1;
      build_expect(thr, ped, sp, nb, dy);
      @(posedge clk);
      lat = 0;
      do begin
         @(negedge clk);
         lat++;
         if (lat == 1) begin
            in_valid = 1'b0;
            if (perturb) begin
               cfg_threshold = ~cfg_threshold; cfg_pedestal = ~cfg_pedestal;
               cfg_sparse = ~cfg_sparse; cfg_neighbour = ~cfg_neighbour; cfg_dyn_ped = ~cfg_dyn_ped;
               in_samples = ~in_samples;
            end
         end
      end while (!out_valid && lat < 10);
      chk(lat == 3, "R8", "first byte latency", lat, 3);
      got_n = 0; gap = 0; rdy_bad = 0;
      for (int k = 0; k < 600; k++) begin
         if (out_valid) begin
            if (got_n < 300) got_b[got_n] = int'(out_data);
            got_n++;
            if (out_last) break;
            if (in_ready) rdy_bad = 1;
         end else gap = 1;
         @(negedge clk);
      end
      chk(!gap, "R8", "stream gap", int'(gap), 0);
      chk(!rdy_bad, "R1", "ready low while emitting", int'(rdy_bad), 0);
      chk(in_ready === 1'b1, "R1", "ready in marker cycle", int'(in_ready), 1);
      chk(out_last === 1'b1 && got_n > 0 && got_b[(got_n - 1) % 300] == 255, "R7", "end marker",
          got_n > 0 ? got_b[(got_n - 1) % 300] : -1, 255);
      chk(got_n == exp_n, req, "byte count", got_n, exp_n);
      bad = 0; first_bad = 0;
      for (int k = 0; k < exp_n && k < got_n && k < 300; k++)
         if (!bad && got_b[k] != exp_b[k]) begin bad = 1; first_bad = k; end
      chk(!bad, req, $sformatf("byte %0d", first_bad), got_b[first_bad], exp_b[first_bad]);
      cfg_threshold = '0; cfg_pedestal = '0; cfg_sparse = 0; cfg_neighbour = 0; cfg_dyn_ped = 0;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      failures++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      chk(in_ready === 1'b1, "R1", "ready in reset", int'(in_ready), 1);
      chk(out_valid === 1'b0, "R1", "valid in reset", int'(out_valid), 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(in_ready === 1'b1 && out_valid === 1'b0, "R1", "state after reset", int'(in_ready), 1);

      // R3: all channels, ramp data, threshold ignored
      for (int i = 0; i < NCH; i++) raw[i] = i;
      run_event(127, 0, 0, 0, 0, 0, "R3");
      // R4: high threshold keeps upper range only
      run_event(100, 0, 1, 0, 0, 0, "R4");
      // R2: saturation with the largest static pedestal, no sparsification
      run_event(0, 63, 0, 0, 0, 0, "R2");
      // R5 R6: edge hits and adjacent hits with neighbour option
      for (int i = 0; i < NCH; i++) raw[i] = 0;
      raw[0] = 100; raw[127] = 100; raw[5] = 100; raw[6] = 100; raw[60] = 100; raw[62] = 100;
      run_event(50, 0, 1, 1, 0, 0, "R5");
      run_event(50, 0, 1, 0, 0, 0, "R6");
      // R7: nothing over threshold, marker only
      for (int i = 0; i < NCH; i++) raw[i] = 10;
      run_event(127, 0, 1, 1, 0, 0, "R7");
      // R2: flat baseline with one spike, dynamic pedestal
      for (int i = 0; i < NCH; i++) raw[i] = 60;
      raw[77] = 120;
      run_event(30, 0, 1, 0, 1, 0, "R2");
      run_event(0, 3, 0, 0, 1, 0, "R2");
      // R9: config and samples changed during emission
      for (int i = 0; i < NCH; i++) raw[i] = (i * 37 + 11) % 128;
      run_event(90, 7, 1, 1, 1, 1, "R9");
      // R4 R5 R2: threshold sweep over pseudo-random events, all mode mixes
      for (int t = 0; t < 128; t += 9) begin
         for (int i = 0; i < NCH; i++) raw[i] = int'($urandom_range(127));
         run_event(t, t % 64, 1, t[0], t[1], 0, "R4");
      end
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule